// File: doc/BRIEF.md
# Page-Buffered Write Commit Unit

This block sits behind the serial slave protocol engine of a byte-addressed nonvolatile store and handles the write side of that store. During a write transaction the engine first hands it the word address. The engine then hands it each received data byte. The unit gathers those bytes in a page buffer of `PAGE_BYTES` entries and keeps one valid flag for each entry. The upper address bits, which pick the page row, stay fixed for the whole transaction. Only the low offset bits advance, and they wrap inside the page. When a transaction sends more bytes than a page holds, the later bytes overwrite the earlier ones.

Nothing reaches the array until the engine reports a stop condition. At that point the unit starts a self-timed programming window of `WRITE_CYCLES` clock cycles and raises `busy_o` for the whole window. The engine uses `busy_o` to withhold every acknowledge, including the one for its own device address. Inside the window, the bytes that were actually received go out on a simple synchronous write port, one per cycle, in ascending offset order. All transaction inputs are ignored while the window is open.

A write-control pin, when high, blocks writes to the top quarter of the array. Bytes aimed there are dropped at arrival, although the engine still acknowledges them. A stop that follows only an address, as in the dummy write that comes before a random read, commits nothing and opens no window. At chip level the write-control pin must be tied low when it is left unused.

Top module: `page_write_commit`

## Requirements
- R1: A pulse on `addr_load_i` latches the page row (`addr_i[ADDR_W-1:OFF_W]`) and the starting offset (`addr_i[OFF_W-1:0]`, where OFF_W = log2 of `PAGE_BYTES`). It also empties the page buffer, so a stop that follows with no bytes commits nothing.
- R2: Each accepted `byte_vld_i` stores `byte_i` at the current offset. The offset then advances modulo `PAGE_BYTES` and the row never changes. After a wrap, a later byte to the same offset replaces the earlier one.
- R3: A `stop_i` pulse while idle, with at least one buffered byte, raises `busy_o` on the next cycle. `busy_o` then stays high for exactly `WRITE_CYCLES` cycles.
- R4: During the window, `mem_we_o` pulses once for each buffered byte, in ascending offset order, with `mem_addr_o` = {row, offset} and `mem_wdata_o` = that byte. Offsets that received no byte are not written, and no write happens outside the window.
- R5: A `stop_i` with an empty buffer leaves `busy_o` low and produces no write.
- R6: While `busy_o` is high, `addr_load_i`, `byte_vld_i` and `stop_i` have no effect. After the window the buffer is empty.
- R7: When `wr_ctrl_i` is high as a byte arrives and the row lies in the top quarter (`addr[ADDR_W-1:ADDR_W-2]` = 2'b11), that byte is not buffered. Bytes in the lower three quarters, and any byte that arrives while `wr_ctrl_i` is low, are buffered normally.
- R8: After reset, `busy_o` and `mem_we_o` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load_i | input | 1 | Word address received (one-cycle strobe) |
| addr_i | input | ADDR_W | Word address of the transaction |
| byte_vld_i | input | 1 | Data byte received (one-cycle strobe) |
| byte_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Stop condition seen (one-cycle strobe) |
| wr_ctrl_i | input | 1 | Write control: high protects the top quarter |
| busy_o | output | 1 | Programming window open; withhold acknowledges |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The assertions assume that the engine's strobes are single-cycle pulses. They also assume that `addr_load_i`, `byte_vld_i` and `stop_i` never coincide, and that a transaction loads its address before it sends any byte. The directed tasks drive each strobe for exactly one cycle and keep them apart. Some of them deliberately fire all three strobes inside an open window, to show that they are ignored there. Expected array writes come from a bench-side page model, which the bench compares in order with the writes it observes.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_PROG = 1'b1
   } seq_state_e;
endpackage

// File: rtl/pwc_prot_guard.sv
module pwc_prot_guard #(
   parameter int ROW_W   = 8,
   parameter bit PROT_EN = 1'b1
) (
   input  logic             wr_ctrl_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             block_o
);
   generate
      if (PROT_EN) begin : g_guard
         // top quarter: two most significant row bits both set
         assign block_o = wr_ctrl_i && (row_i[ROW_W-1:ROW_W-2] == 2'b11);
      end else begin : g_open
         logic unused_in;
         assign unused_in = wr_ctrl_i ^ (^row_i);
         assign block_o   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int ROW_W     = ADDR_W - OFF_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_load_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  byte_we_i,
   input  logic [DATA_W-1:0]     byte_i,
   input  logic                  clear_i,
   input  logic [OFF_W-1:0]      rd_idx_i,
   output logic [ROW_W-1:0]      row_o,
   output logic [PAGE_BYTES-1:0] mask_o,
   output logic [DATA_W-1:0]     rd_data_o
);
   logic [DATA_W-1:0] slot_q [PAGE_BYTES];
   logic [OFF_W-1:0]  ptr_q;
   logic [ROW_W-1:0]  row_q;
   logic [PAGE_BYTES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         row_q  <= '0;
         mask_q <= '0;
      end else if (addr_load_i) begin
         row_q  <= addr_i[ADDR_W-1:OFF_W];
         ptr_q  <= addr_i[OFF_W-1:0];
         mask_q <= '0;
      end else if (clear_i) begin
         mask_q <= '0;
      end else if (byte_we_i) begin
         mask_q[ptr_q] <= 1'b1;
         ptr_q         <= ptr_q + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (byte_we_i && !addr_load_i && !clear_i && (ptr_q == OFF_W'(i)))
               slot_q[i] <= byte_i;
         end
      end
   endgenerate

   assign row_o     = row_q;
   assign mask_o    = mask_q;
   assign rd_data_o = slot_q[rd_idx_i];

   p_offset_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we_i && !addr_load_i && !clear_i && ptr_q == OFF_W'(PAGE_BYTES-1)) |=> (ptr_q == '0));
   p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we_i && !addr_load_i) |=> $stable(row_q));
   p_load_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load_i |=> (mask_q == '0));
endmodule

// File: rtl/pwc_commit_seq.sv
module pwc_commit_seq
   import pwc_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 32,
   parameter int WRITE_CYCLES = 40,
   localparam int OFF_W       = $clog2(PAGE_BYTES),
   localparam int ROW_W       = ADDR_W - OFF_W,
   localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stop_i,
   input  logic [PAGE_BYTES-1:0] mask_i,
   input  logic [ROW_W-1:0]      row_i,
   input  logic [DATA_W-1:0]     rd_data_i,
   output logic [OFF_W-1:0]      rd_idx_o,
   output logic                  clear_o,
   output logic                  busy_o,
   output logic                  mem_we_o,
   output logic [ADDR_W-1:0]     mem_addr_o,
   output logic [DATA_W-1:0]     mem_wdata_o
);
   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_c;

   assign last_c = (state_q == SEQ_PROG) && (cnt_q == CNT_W'(WRITE_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (stop_i && (|mask_i)) begin
               state_q <= SEQ_PROG;
               cnt_q   <= '0;
            end
            SEQ_PROG: if (last_c) begin
               state_q <= SEQ_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q == SEQ_PROG);
   assign clear_o     = last_c;
   assign rd_idx_o    = cnt_q[OFF_W-1:0];
   assign mem_we_o    = busy_o && (cnt_q < CNT_W'(PAGE_BYTES)) && mask_i[rd_idx_o];
   assign mem_addr_o  = {row_i, rd_idx_o};
   assign mem_wdata_o = rd_data_i;

   p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(stop_i) && ($past(mask_i) != '0)));
   p_empty_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && stop_i && mask_i == '0) |=> !busy_o);
   p_write_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o);
   p_reset_idle_r8: assert property (@(posedge clk)
      !rst_n |-> (!busy_o && !mem_we_o));
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit #(
   parameter int ADDR_W       = 13,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 32,
   parameter int WRITE_CYCLES = 40,
   parameter bit PROT_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              wr_ctrl_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);
   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int ROW_W = ADDR_W - OFF_W;

   generate
      if ((PAGE_BYTES < 2) || ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (ROW_W < 2) begin : g_bad_row
         $error("ADDR_W must leave at least two row bits");
      end
      if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_cycles
         $error("WRITE_CYCLES must cover one write per page slot");
      end
   endgenerate

   logic [ROW_W-1:0]      row_w;
   logic [PAGE_BYTES-1:0] mask_w;
   logic [DATA_W-1:0]     rd_data_w;
   logic [OFF_W-1:0]      rd_idx_w;
   logic                  clear_w, block_w, busy_w;
   logic                  ld_ok, byte_ok, stop_ok;

   assign ld_ok   = addr_load_i && !busy_w;
   assign byte_ok = byte_vld_i && !busy_w && !block_w;
   assign stop_ok = stop_i && !busy_w;

   pwc_prot_guard #(.ROW_W(ROW_W), .PROT_EN(PROT_EN)) u_guard (
      .wr_ctrl_i (wr_ctrl_i),
      .row_i     (row_w),
      .block_o   (block_w)
   );

   pwc_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_load_i (ld_ok),
      .addr_i      (addr_i),
      .byte_we_i   (byte_ok),
      .byte_i      (byte_i),
      .clear_i     (clear_w),
      .rd_idx_i    (rd_idx_w),
      .row_o       (row_w),
      .mask_o      (mask_w),
      .rd_data_o   (rd_data_w)
   );

   pwc_commit_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
                    .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .stop_i      (stop_ok),
      .mask_i      (mask_w),
      .row_i       (row_w),
      .rd_data_i   (rd_data_w),
      .rd_idx_o    (rd_idx_w),
      .clear_o     (clear_w),
      .busy_o      (busy_w),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o)
   );

   assign busy_o = busy_w;

   p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && !clear_w) |=> ($stable(mask_w) && $stable(row_w)));
   p_window_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_w) |-> (mask_w == '0));
   p_protect_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && block_w && !addr_load_i && !busy_w) |=> $stable(mask_w));
endmodule

// File: tb/page_write_commit_bench.sv
module page_write_commit_bench;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int PB = 32;
   localparam int WC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_load_i = 1'b0, byte_vld_i = 1'b0, stop_i = 1'b0, wr_ctrl_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] byte_i = '0;
   logic busy_o, mem_we_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o;

   int n_chk = 0;
   int n_bad = 0;

   // expected page model
   logic [7:0]    m_row;
   logic [4:0]    m_ptr;
   logic [DW-1:0] m_data [PB];
   logic [PB-1:0] m_mask;

   logic [AW-1:0] q_addr [$];
   logic [DW-1:0] q_data [$];

   always #2 clk = ~clk;

   page_write_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_page_write_commit (
      .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .wr_ctrl_i(wr_ctrl_i),
      .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
   );

   always @(negedge clk) begin
      if (mem_we_o) begin
         q_addr.push_back(mem_addr_o);
         q_data.push_back(mem_wdata_o);
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_addr(input logic [AW-1:0] a);
      @(negedge clk); addr_load_i = 1'b1; addr_i = a;
      @(negedge clk); addr_load_i = 1'b0;
      m_row = a[12:5]; m_ptr = a[4:0]; m_mask = '0;
   endtask

   task automatic send_byte(input logic [DW-1:0] d, input logic wc);
      @(negedge clk); byte_vld_i = 1'b1; byte_i = d; wr_ctrl_i = wc;
      @(negedge clk); byte_vld_i = 1'b0; wr_ctrl_i = 1'b0;
      if (!(wc && m_row[7:6] == 2'b11)) begin
         m_data[m_ptr] = d;
         m_mask[m_ptr] = 1'b1;
         m_ptr = m_ptr + 5'd1;
      end
   endtask

   // stop, then measure the window; optionally inject strobes inside it
   task automatic stop_and_measure(input string req, input logic expect_busy, input logic poke);
      int n;
      q_addr.delete(); q_data.delete();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      check({req, " busy after stop"}, busy_o, expect_busy);
      n = 0;
      while (busy_o && n < 4 * WC) begin
         if (poke && n == 3) begin addr_load_i = 1'b1; addr_i = 13'h0123; end
         else if (poke && n == 4) begin addr_load_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'hEE; end
         else if (poke && n == 5) begin byte_vld_i = 1'b0; stop_i = 1'b1; end
         else begin addr_load_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0; end
         n++;
         @(negedge clk);
      end
      addr_load_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0;
      check({req, " window length"}, n, expect_busy ? WC : 0);
   endtask

   task automatic compare_writes(input string req);
      int k;
      k = 0;
      for (int off = 0; off < PB; off++) begin
         if (m_mask[off]) begin
            if (k < q_addr.size()) begin
               check({req, " write addr"}, q_addr[k], {m_row, 5'(off)});
               check({req, " write data"}, q_data[k], m_data[off]);
            end
            k++;
         end
      end
      check({req, " write count"}, q_addr.size(), k);
      m_mask = '0;
   endtask

   task automatic t_reset_r8;
      check("R8 busy at reset", busy_o, 1'b0);
      check("R8 we at reset", mem_we_o, 1'b0);
      stop_and_measure("R8 empty buffer", 1'b0, 1'b0);
      check("R8 no writes", q_addr.size(), 0);
   endtask

   task automatic t_partial_r4;
      send_addr(13'h0104);
      send_byte(8'hA1, 1'b0);
      send_byte(8'hB2, 1'b0);
      send_byte(8'hC3, 1'b0);
      stop_and_measure("R3", 1'b1, 1'b0);
      compare_writes("R4 partial page");
   endtask

   task automatic t_wrap_r2;
      send_addr(13'h005E);
      for (int i = 0; i < 34; i++) send_byte(8'(8'h10 + i), 1'b0);
      check("R2 wrapped offset 30 holds last", m_data[30], 8'h30);
      stop_and_measure("R3 wrap", 1'b1, 1'b0);
      compare_writes("R2 wrap");
   endtask

   task automatic t_dummy_r5;
      send_addr(13'h0A00);
      stop_and_measure("R5 dummy write", 1'b0, 1'b0);
      check("R5 no writes", q_addr.size(), 0);
   endtask

   task automatic t_reload_r1;
      send_addr(13'h0200);
      send_byte(8'h55, 1'b0);
      send_addr(13'h0300);
      stop_and_measure("R1 reload empties", 1'b0, 1'b0);
      check("R1 no writes", q_addr.size(), 0);
   endtask

   task automatic t_busy_r6;
      send_addr(13'h0440);
      send_byte(8'h77, 1'b0);
      stop_and_measure("R6 window", 1'b1, 1'b1);
      compare_writes("R6 writes unaffected");
      stop_and_measure("R6 drained", 1'b0, 1'b0);
      check("R6 no stray writes", q_addr.size(), 0);
   endtask

   task automatic t_protect_r7;
      send_addr(13'h1F00);
      send_byte(8'h01, 1'b1);
      send_byte(8'h02, 1'b1);
      stop_and_measure("R7 all protected", 1'b0, 1'b0);
      check("R7 no writes", q_addr.size(), 0);
      send_addr(13'h1F10);
      send_byte(8'h0A, 1'b0);
      send_byte(8'h0B, 1'b1);
      send_byte(8'h0C, 1'b0);
      stop_and_measure("R7 mixed", 1'b1, 1'b0);
      compare_writes("R7 mixed");
      send_addr(13'h0100);
      send_byte(8'h3C, 1'b1);
      stop_and_measure("R7 low quarter", 1'b1, 1'b0);
      compare_writes("R7 low quarter");
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      m_mask = '0; m_row = '0; m_ptr = '0;
      repeat (3) @(negedge clk);
      t_reset_r8();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_r8();
      t_partial_r4();
      t_wrap_r2();
      t_dummy_r5();
      t_reload_r1();
      t_busy_r6();
      t_protect_r7();
      summary();
      $finish;
   end
endmodule